// File: doc/BRIEF.md
# Speculative-Isolation Coherence Line Controller

This block is the per-line coherence state machine of a private L1 cache. It extends the four classic MESI states with two transactional states. The speculative state holds stores buffered by the running transaction. The isolated state holds a read-only copy that is shielded from other cores' speculative writers. Several cores may hold the same line in the speculative state at once. Commit and revert are applied locally in a single cycle and put nothing on the bus.

Each cycle the controller sees at most one local operation and at most one snooped bus request. It answers in the same cycle with the next state, the bus request to issue, and the snoop response flags. It also raises an alert when a speculatively written line would have to leave the cache. For a miss, the fill's shared and threatened response flags are taken in the same cycle as the request, because arbitration and the data arrays are outside this block.

Top module: `spec_line_ctrl`

## Requirements
- R1: Encodings. line_state and next_state use Invalid=0, Shared=1, Exclusive=2, Modified=3, Speculative=4, Isolated=5. local_op uses none=0, load=1, store=2, tload=3, tstore=4, commit=5, revert=6, evict=7. snoop_op uses none=0, read=1, read-exclusive=2, transactional read-exclusive=3. bus_req uses none=0, read=1, read-exclusive=2, transactional read-exclusive=3. A synchronous active-low reset sets line_state to 0. With both operation inputs at 0, all outputs are 0 and next_state equals line_state.
- R2: A tstore in any state except Speculative issues bus_req 3, and the line becomes Speculative. A tstore to a Speculative line issues no request and the state is unchanged.
- R3: A snooped transactional read-exclusive to a Speculative line leaves it Speculative. It raises no threatened, suppress or conflict flag.
- R4: A snooped read to a Speculative line asserts threatened and suppress_data, and the state is unchanged.
- R5: A snooped read-exclusive to a Speculative line leaves the state unchanged and asserts conflict.
- R6: A tload to an Invalid line issues bus_req 1. The line becomes Isolated if fill_threat is set, else Shared if fill_shared is set, else Exclusive. A tload that hits leaves the state unchanged.
- R7: An Isolated line that snoops a read-exclusive, or that is evicted, becomes Invalid with alert low.
- R8: Commit moves Speculative to Modified and Isolated to Invalid. All other states are unchanged, and no bus request is issued.
- R9: Revert moves Speculative and Isolated to Invalid. All other states are unchanged, and no bus request is issued.
- R10: Evicting a Speculative line asserts alert and the line stays Speculative. Evicting any other line makes it Invalid with alert low.
- R11: The plain MESI transitions are as follows.
  - A load miss issues a read. It fills Shared if fill_shared or fill_threat is set, else Exclusive.
  - A store to Invalid, Shared or Isolated issues a read-exclusive and goes to Modified. A store to Exclusive goes to Modified silently. A store to Modified or Speculative is unchanged.
  - A snooped read moves Modified or Exclusive to Shared.
  - A snooped read-exclusive moves Modified, Exclusive or Shared to Invalid.
  - A snooped transactional read-exclusive moves Modified or Exclusive to Shared.
- R12: When a snoop and a local operation arrive in the same cycle, only the snoop is applied. The local operation has no effect on any output.
- R13: line_state after a rising clock edge equals the next_state shown before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_op | input | 3 | Local operation code |
| snoop_op | input | 2 | Snooped bus request code |
| fill_shared | input | 1 | Miss fill reports other sharers |
| fill_threat | input | 1 | Miss fill came back threatened |
| line_state | output | 3 | Registered line state |
| next_state | output | 3 | State taken at the next edge |
| bus_req | output | 2 | Bus request to issue this cycle |
| suppress_data | output | 1 | Withhold data from the snoop response |
| threatened | output | 1 | Mark the snoop response threatened |
| alert | output | 1 | Speculative line eviction attempted |
| conflict | output | 1 | Plain exclusive request hit a speculative line |

## Verification
Directed sequences first drive the line into the Speculative state and send each of the three snoop kinds to it. This separates ignored, threatened and conflict responses. Tload misses are run with each combination of fill flags, so that the Isolated, Shared and Exclusive fills are told apart. Commit, revert and evict are applied to both transactional states to separate their local exits. Random operation streams with a fixed seed then walk all six states, with snoops and local operations often colliding. Every output is compared each cycle against a bench model of the requirements.

// File: rtl/spec_line_pkg.sv
// Shared encodings of the speculative-isolation line controller.
// Assumes: one line per instance; codes are fixed by the port contract.
package spec_line_pkg;
    localparam int ST_W  = 3;
    localparam int OP_W  = 3;
    localparam int SN_W  = 2;
    localparam int BR_W  = 2;

    typedef enum logic [ST_W-1:0] {
        LN_INV  = 3'd0,
        LN_SHR  = 3'd1,
        LN_EXC  = 3'd2,
        LN_MOD  = 3'd3,
        LN_SPEC = 3'd4,
        LN_ISO  = 3'd5
    } line_st_e;

    typedef enum logic [OP_W-1:0] {
        OP_NONE   = 3'd0,
        OP_LD     = 3'd1,
        OP_ST     = 3'd2,
        OP_TLD    = 3'd3,
        OP_TST    = 3'd4,
        OP_COMMIT = 3'd5,
        OP_REVERT = 3'd6,
        OP_EVICT  = 3'd7
    } loc_op_e;

    typedef enum logic [SN_W-1:0] {
        SN_NONE = 2'd0,
        SN_RD   = 2'd1,
        SN_RDX  = 2'd2,
        SN_TRDX = 2'd3
    } snp_e;

    typedef enum logic [BR_W-1:0] {
        BR_NONE = 2'd0,
        BR_RD   = 2'd1,
        BR_RDX  = 2'd2,
        BR_TRDX = 2'd3
    } bus_req_e;
endpackage

// File: rtl/spec_line_local.sv
// Local-side transition logic: maps the current state and one local
// operation to the next state, the bus request and the eviction alert.
// Assumes: a miss fill's shared/threatened flags arrive in the same cycle.
module spec_line_local
    import spec_line_pkg::*;
(
    input  line_st_e cur_st,
    input  loc_op_e  op,
    input  logic     fill_shared,
    input  logic     fill_threat,
    output line_st_e nxt_st,
    output bus_req_e req,
    output logic     evict_alert
);
    // Next state and request for the local operation
    always_comb begin
        nxt_st      = cur_st;
        req         = BR_NONE;
        evict_alert = 1'b0;
        unique case (op)
            OP_LD: begin
                if (cur_st == LN_INV) begin
                    req    = BR_RD;
                    nxt_st = (fill_shared || fill_threat) ? LN_SHR : LN_EXC;
                end
            end
            OP_TLD: begin
                if (cur_st == LN_INV) begin
                    req = BR_RD;
                    if (fill_threat)      nxt_st = LN_ISO;
                    else if (fill_shared) nxt_st = LN_SHR;
                    else                  nxt_st = LN_EXC;
                end
            end
            OP_ST: begin
                if (cur_st == LN_INV || cur_st == LN_SHR || cur_st == LN_ISO) begin
                    req    = BR_RDX;
                    nxt_st = LN_MOD;
                end else if (cur_st == LN_EXC) begin
                    nxt_st = LN_MOD;
                end
            end
            OP_TST: begin
                if (cur_st != LN_SPEC) begin
                    req    = BR_TRDX;
                    nxt_st = LN_SPEC;
                end
            end
            OP_COMMIT: begin
                if (cur_st == LN_SPEC)     nxt_st = LN_MOD;
                else if (cur_st == LN_ISO) nxt_st = LN_INV;
            end
            OP_REVERT: begin
                if (cur_st == LN_SPEC || cur_st == LN_ISO) nxt_st = LN_INV;
            end
            OP_EVICT: begin
                if (cur_st == LN_SPEC) evict_alert = 1'b1;
                else                   nxt_st      = LN_INV;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spec_line_snoop.sv
// Snoop-side transition logic: maps the current state and one snooped
// bus request to the next state and the response flags.
// Assumes: data supply itself is handled outside this block.
module spec_line_snoop
    import spec_line_pkg::*;
(
    input  line_st_e cur_st,
    input  snp_e     snp,
    output line_st_e nxt_st,
    output logic     sup_data,
    output logic     thr_resp,
    output logic     wr_conflict
);
    // Next state and response flags for the snooped request
    always_comb begin
        nxt_st      = cur_st;
        sup_data    = 1'b0;
        thr_resp    = 1'b0;
        wr_conflict = 1'b0;
        unique case (snp)
            SN_RD: begin
                if (cur_st == LN_SPEC) begin
                    sup_data = 1'b1;
                    thr_resp = 1'b1;
                end else if (cur_st == LN_MOD || cur_st == LN_EXC) begin
                    nxt_st = LN_SHR;
                end
            end
            SN_RDX: begin
                if (cur_st == LN_SPEC) wr_conflict = 1'b1;
                else                   nxt_st      = LN_INV;
            end
            SN_TRDX: begin
                if (cur_st == LN_MOD || cur_st == LN_EXC) nxt_st = LN_SHR;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spec_line_ctrl.sv
// Top of the per-line controller: holds the line state, gives a snoop
// priority over a local operation arriving in the same cycle, and drives
// the combinational response outputs.
// Assumes: synchronous active-low reset; at most one of each op per cycle.
module spec_line_ctrl
    import spec_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] local_op,
    input  logic [1:0] snoop_op,
    input  logic       fill_shared,
    input  logic       fill_threat,
    output logic [2:0] line_state,
    output logic [2:0] next_state,
    output logic [1:0] bus_req,
    output logic       suppress_data,
    output logic       threatened,
    output logic       alert,
    output logic       conflict
);
    line_st_e state_q;
    line_st_e loc_nxt, snp_nxt, sel_nxt;
    bus_req_e loc_req;
    logic     loc_alert, snp_sup, snp_thr, snp_cnf;
    logic     snoop_act;

    assign snoop_act = (snp_e'(snoop_op) != SN_NONE);

    spec_line_local u_local (
        .cur_st      (state_q),
        .op          (loc_op_e'(local_op)),
        .fill_shared (fill_shared),
        .fill_threat (fill_threat),
        .nxt_st      (loc_nxt),
        .req         (loc_req),
        .evict_alert (loc_alert)
    );

    spec_line_snoop u_snoop (
        .cur_st      (state_q),
        .snp         (snp_e'(snoop_op)),
        .nxt_st      (snp_nxt),
        .sup_data    (snp_sup),
        .thr_resp    (snp_thr),
        .wr_conflict (snp_cnf)
    );

    // Select the snoop result over the local result
    always_comb begin
        sel_nxt = snoop_act ? snp_nxt : loc_nxt;
    end

    // Line state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LN_INV;
        else        state_q <= sel_nxt;
    end

    assign line_state    = state_q;
    assign next_state    = sel_nxt;
    assign bus_req       = snoop_act ? BR_NONE : loc_req;
    assign alert         = snoop_act ? 1'b0 : loc_alert;
    assign suppress_data = snp_sup;
    assign threatened    = snp_thr;
    assign conflict      = snp_cnf;

    // R2: transactional store from a non-speculative line lands speculative
    a_r2_tstore_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (!snoop_act && local_op == OP_TST && state_q != LN_SPEC)
        |-> (bus_req == BR_TRDX) ##1 (line_state == LN_SPEC));

    // R3: speculative line keeps its state under a transactional snoop
    a_r3_trdx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_op == SN_TRDX && state_q == LN_SPEC)
        |=> (line_state == LN_SPEC));

    // R4: plain read to speculative line is threatened with data withheld
    a_r4_threat_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_op == SN_RD && state_q == LN_SPEC)
        |-> (threatened && suppress_data));

    // R5: plain exclusive request to speculative line flags a conflict
    a_r5_conflict_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_op == SN_RDX && state_q == LN_SPEC)
        |-> conflict ##1 (line_state == LN_SPEC));

    // R7: isolated line leaves silently
    a_r7_iso_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_ISO && !snoop_act && local_op == OP_EVICT)
        |-> !alert ##1 (line_state == LN_INV));

    // R8: commit is local
    a_r8_commit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!snoop_act && local_op == OP_COMMIT) |-> (bus_req == BR_NONE));

    // R10: an alert means the line is still resident afterwards
    a_r10_alert_resident: assert property (@(posedge clk) disable iff (!rst_n)
        alert |-> (state_q == LN_SPEC) ##1 (line_state == LN_SPEC));

    // R12: a snoop cycle never issues a local bus request
    a_r12_snoop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_act |-> (bus_req == BR_NONE && !alert));

    // R13: registered state follows the shown next state
    a_r13_next_taken: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (line_state == $past(next_state)));
endmodule

// File: tb/spec_line_ctrl_tb.sv
module spec_line_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] local_op = '0;
    logic [1:0] snoop_op = '0;
    logic       fill_shared = 1'b0;
    logic       fill_threat = 1'b0;
    logic [2:0] line_state, next_state;
    logic [1:0] bus_req;
    logic       suppress_data, threatened, alert, conflict;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] exp_st = 3'd0;

    typedef struct packed {
        logic [2:0] nx;
        logic [1:0] br;
        logic       sup;
        logic       thr;
        logic       alr;
        logic       cnf;
    } exp_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_line_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .local_op(local_op), .snoop_op(snoop_op),
        .fill_shared(fill_shared), .fill_threat(fill_threat),
        .line_state(line_state), .next_state(next_state), .bus_req(bus_req),
        .suppress_data(suppress_data), .threatened(threatened),
        .alert(alert), .conflict(conflict)
    );

    // Expected behaviour from the requirements (states I0 S1 E2 M3 P4 T5)
    function automatic exp_t model(input logic [2:0] s, input logic [2:0] op,
                                   input logic [1:0] sn, input logic fs,
                                   input logic ft);
        exp_t e;
        e = '0;
        e.nx = s;
        if (sn != 2'd0) begin
            case (sn)
                2'd1: if (s == 3'd4) begin e.sup = 1; e.thr = 1; end
                      else if (s == 3'd3 || s == 3'd2) e.nx = 3'd1;
                2'd2: if (s == 3'd4) e.cnf = 1; else e.nx = 3'd0;
                default: if (s == 3'd3 || s == 3'd2) e.nx = 3'd1;
            endcase
        end else begin
            case (op)
                3'd1: if (s == 3'd0) begin e.br = 2'd1; e.nx = (fs || ft) ? 3'd1 : 3'd2; end
                3'd2: if (s == 3'd0 || s == 3'd1 || s == 3'd5) begin e.br = 2'd2; e.nx = 3'd3; end
                      else if (s == 3'd2) e.nx = 3'd3;
                3'd3: if (s == 3'd0) begin
                          e.br = 2'd1;
                          e.nx = ft ? 3'd5 : (fs ? 3'd1 : 3'd2);
                      end
                3'd4: if (s != 3'd4) begin e.br = 2'd3; e.nx = 3'd4; end
                3'd5: if (s == 3'd4) e.nx = 3'd3; else if (s == 3'd5) e.nx = 3'd0;
                3'd6: if (s == 3'd4 || s == 3'd5) e.nx = 3'd0;
                3'd7: if (s == 3'd4) e.alr = 1; else e.nx = 3'd0;
                default: ;
            endcase
        end
        return e;
    endfunction

    // Requirement exercised by a stimulus
    function automatic string tag_of(input logic [2:0] s, input logic [2:0] op,
                                     input logic [1:0] sn);
        if (sn != 2'd0 && op != 3'd0) return "R12";
        if (sn == 2'd3 && s == 3'd4) return "R3";
        if (sn == 2'd1 && s == 3'd4) return "R4";
        if (sn == 2'd2 && s == 3'd4) return "R5";
        if (sn == 2'd2 && s == 3'd5) return "R7";
        if (sn != 2'd0) return "R11";
        case (op)
            3'd3: return "R6";
            3'd4: return "R2";
            3'd5: return "R8";
            3'd6: return "R9";
            3'd7: return (s == 3'd5) ? "R7" : "R10";
            3'd0: return "R1";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one vector, check responses, clock it, check the new state
    task automatic apply(input logic [2:0] op, input logic [1:0] sn,
                         input logic fs, input logic ft);
        exp_t e;
        string tg;
        @(negedge clk);
        local_op = op; snoop_op = sn; fill_shared = fs; fill_threat = ft;
        e  = model(exp_st, op, sn, fs, ft);
        tg = tag_of(exp_st, op, sn);
        #1;
        chk(tg, "next_state", {5'd0, next_state}, {5'd0, e.nx});
        chk(tg, "bus_req", {6'd0, bus_req}, {6'd0, e.br});
        chk(tg, "suppress", {7'd0, suppress_data}, {7'd0, e.sup});
        chk(tg, "threatened", {7'd0, threatened}, {7'd0, e.thr});
        chk(tg, "alert", {7'd0, alert}, {7'd0, e.alr});
        chk(tg, "conflict", {7'd0, conflict}, {7'd0, e.cnf});
        @(posedge clk);
        #1;
        exp_st = e.nx;
        chk("R13", "line_state", {5'd0, line_state}, {5'd0, exp_st});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        local_op = 3'd0; snoop_op = 2'd0;
        repeat (2) @(posedge clk);
        #1;
        exp_st = 3'd0;
        chk("R1", "reset state", {5'd0, line_state}, 8'd0);
        chk("R1", "reset bus_req", {6'd0, bus_req}, 8'd0);
        chk("R1", "reset flags", {4'd0, suppress_data, threatened, alert, conflict}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        do_reset();
        apply(3'd0, 2'd0, 0, 0);          // R1 idle
        // R2, R3, R4, R5 on a speculative line
        apply(3'd4, 2'd0, 0, 0);
        apply(3'd4, 2'd0, 0, 0);
        apply(3'd0, 2'd3, 0, 0);
        apply(3'd0, 2'd1, 0, 0);
        apply(3'd0, 2'd2, 0, 0);
        // R10 eviction of speculative line, then R8 commit
        apply(3'd7, 2'd0, 0, 0);
        apply(3'd5, 2'd0, 0, 0);
        // R11 snoop read on M, R12 collision
        apply(3'd0, 2'd1, 0, 0);
        apply(3'd4, 2'd2, 0, 0);
        // R6 tload fills: isolated, shared, exclusive
        apply(3'd3, 2'd0, 1, 1);
        apply(3'd7, 2'd0, 0, 0);          // R7 silent eviction
        apply(3'd3, 2'd0, 1, 0);
        apply(3'd0, 2'd2, 0, 0);
        apply(3'd3, 2'd0, 0, 0);
        // R9 revert of speculative and isolated lines
        apply(3'd4, 2'd0, 0, 0);
        apply(3'd6, 2'd0, 0, 0);
        apply(3'd3, 2'd0, 0, 1);
        apply(3'd0, 2'd2, 0, 0);          // R7 invalidation of isolated
        apply(3'd3, 2'd0, 0, 1);
        apply(3'd6, 2'd0, 0, 0);
        apply(3'd3, 2'd0, 0, 1);
        apply(3'd5, 2'd0, 0, 0);          // R8 commit of isolated
        // Random mix
        for (int i = 0; i < N_RAND; i++) begin
            logic [1:0] sn;
            sn = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            apply(3'($urandom_range(0, 7)), sn,
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        do_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule